// File: doc/BRIEF.md
# Fully Associative Cache Controller with Background Line Fill

This block controls a small fully associative cache of four-word lines and a separate line-fetch buffer that holds the line being loaded. A read that misses loads the new line into the buffer. The missing word is fetched from external memory before the other words of its line, and it is handed to the processor in the same cycle the memory returns it. The remaining three words then arrive in the background while the processor goes on reading lines already in the array.

The buffer has its own tag, so a read of a buffered word that has arrived is served like any array hit. A read of a buffered word that has not arrived yet waits until it arrives. The buffer line moves into a randomly chosen array line only when the next miss starts. A read of the word just after the previously read word, inside the same line, is served from the entry that supplied the previous read, and the associative compare is not used. Writes go through to external memory and also update any cached copy of the word.

Top module: `lfb_cache`

## Requirements
- R1: After reset, `cpu_ack`, `cpu_seq` and `mem_req` are low, and no line is valid: the first read after reset is fetched from memory.
- R2: On a read miss the first memory read uses the requested word address itself. The processor is acknowledged with `mem_rdata` in the same cycle that `mem_ack` returns that word.
- R3: After the first word of a line, the other three words are read from memory in ascending offset order, wrapping from offset 3 to 0 (address bits [1:0] give the offset and the bits above give the tag). Reads that hit array lines are acknowledged while this fill is still in progress.
- R4: A read of a word that is already in the fill buffer is acknowledged in the cycle it is presented, without a memory access.
- R5: A read that matches the buffer tag on a word not yet fetched waits, and it is acknowledged with the memory data in the cycle that word arrives. No extra memory read is made.
- R6: When a new miss starts, the line held in the buffer is written into the array. Later reads of that line hit without memory traffic.
- R7: `cpu_seq` is high, together with `cpu_ack`, when the read address equals the previous acknowledged read address plus one, both addresses lie in the same line, and the word is present. Crossing into a new line gives `cpu_seq` low.
- R8: A write drives `mem_req` with `mem_we` high, the processor address and the processor data. It is acknowledged in the `mem_ack` cycle. A cached copy of the word, in the array or the buffer, takes the new value.
- R9: Only one memory transaction is outstanding at a time. A miss or a write that arrives during a fill waits until the last word of the fill has arrived, and `mem_addr` and `mem_we` stay steady until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req | input | 1 | Processor request, held until `cpu_ack` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address: [1:0] offset in line, upper bits tag |
| cpu_wdata | input | DW | Write data |
| cpu_ack | output | 1 | Request completes this cycle |
| cpu_rdata | output | DW | Read data, valid with `cpu_ack` |
| cpu_seq | output | 1 | Read served by the sequential path, without tag search |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | Memory write when high |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | One-cycle completion of the current memory request |
| mem_rdata | input | DW | Memory read data, valid with `mem_ack` |

## Verification
The main read path is tried with misses at a middle offset, which tell critical-word-first apart from line-aligned fetching and show the wrap order. Reads of committed lines during a fill show whether the fill blocks the processor. Reads of buffered words that have arrived, and of words that have not, separate an immediate buffer hit from a stall that ends on data forwarded from memory. Ascending read runs that cross a line boundary separate the sequential path from a tag search. A second miss or a write issued during a fill shows whether memory traffic is serialised and whether the buffer is committed at the right moment.

// File: rtl/lfb_cache_pkg.sv
package lfb_cache_pkg;
  // four-word lines: offset field is two bits wide
  localparam int unsigned LINE_WORDS = 4;
  localparam int unsigned OFF_W      = 2;

  function automatic logic [OFF_W-1:0] wrap_next(input logic [OFF_W-1:0] off);
    return off + 1'b1;
  endfunction
endpackage

// File: rtl/lfb_lfsr.sv
module lfb_lfsr #(
  parameter int unsigned        W    = 8,
  parameter logic [W-1:0]       TAPS = 8'hB8
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state
);
  logic [W-1:0] state_n;

  always_comb begin
    state_n = {1'b0, state[W-1:1]} ^ (state[0] ? TAPS : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= {{(W-1){1'b0}}, 1'b1};
    else        state <= state_n;
  end
endmodule

// File: rtl/lfb_tag_match.sv
module lfb_tag_match #(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned TAG_W   = 8,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0][TAG_W-1:0] tags,
  input  logic [ENTRIES-1:0]            valid,
  input  logic [TAG_W-1:0]              key,
  output logic                          hit,
  output logic [IDX_W-1:0]              idx
);
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid[g] && (tags[g] == key);
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) idx = IDX_W'(i);
    end
    hit = |match;
  end
endmodule

// File: rtl/lfb_cache.sv
module lfb_cache #(
  parameter int unsigned AW        = 10,
  parameter int unsigned DW        = 16,
  parameter int unsigned LINES     = 4,
  parameter int unsigned LFSR_W    = 8,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_ack,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_seq,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);
  import lfb_cache_pkg::*;

  localparam int unsigned LW    = LINE_WORDS;
  localparam int unsigned TAG_W = AW - OFF_W;
  localparam int unsigned IDX_W = $clog2(LINES);

  // reset synchroniser: asserted at once, released on the clock
  logic [1:0] rsync;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= '0;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign srst_n = rsync[1];

  // array and buffer state
  logic [LINES-1:0][TAG_W-1:0]       line_tag, line_tag_n;
  logic [LINES-1:0]                  line_vld, line_vld_n;
  logic [LINES-1:0][LW-1:0][DW-1:0]  line_dat, line_dat_n;
  logic [TAG_W-1:0]                  buf_tag, buf_tag_n;
  logic                              buf_vld, buf_vld_n;
  logic [LW-1:0]                     buf_wv, buf_wv_n;
  logic [LW-1:0][DW-1:0]             buf_dat, buf_dat_n;
  logic                              fill_busy, fill_busy_n;
  logic [OFF_W-1:0]                  fill_ptr, fill_ptr_n;
  logic [OFF_W-1:0]                  fill_cnt, fill_cnt_n;
  logic                              last_vld, last_vld_n;
  logic                              last_buf, last_buf_n;
  logic [IDX_W-1:0]                  last_idx, last_idx_n;
  logic [AW-1:0]                     last_addr, last_addr_n;
  logic [LFSR_W-1:0]                 rnd;

  // request decode
  logic [TAG_W-1:0] req_tag;
  logic [OFF_W-1:0] req_off;
  logic             arr_hit, buf_match, fill_here, seq_ok, rd, miss_start, wr_done;
  logic [IDX_W-1:0] arr_idx, src_idx;
  logic             src_buf;

  assign req_tag = cpu_addr[AW-1:OFF_W];
  assign req_off = cpu_addr[OFF_W-1:0];
  assign rd      = cpu_req && !cpu_we;

  lfb_tag_match #(.ENTRIES(LINES), .TAG_W(TAG_W)) i_match (
    .tags(line_tag), .valid(line_vld), .key(req_tag), .hit(arr_hit), .idx(arr_idx)
  );

  lfb_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS)) i_rand (
    .clk(clk), .rst_n(srst_n), .state(rnd)
  );

  assign buf_match = buf_vld && (buf_tag == req_tag);
  assign fill_here = fill_busy && mem_ack && buf_match && (fill_ptr == req_off);
  assign seq_ok    = last_vld && (cpu_addr == last_addr + 1'b1) && (req_off != '0)
                     && (!last_buf || buf_wv[req_off]);
  assign miss_start = rd && !seq_ok && !arr_hit && !buf_match && !fill_busy;
  assign wr_done    = cpu_req && cpu_we && !fill_busy && mem_ack;

  // response selection
  always_comb begin
    cpu_ack   = 1'b0;
    cpu_seq   = 1'b0;
    cpu_rdata = '0;
    src_buf   = 1'b0;
    src_idx   = arr_idx;
    if (rd) begin
      if (seq_ok) begin
        cpu_ack   = 1'b1;
        cpu_seq   = 1'b1;
        src_buf   = last_buf;
        src_idx   = last_idx;
        cpu_rdata = last_buf ? buf_dat[req_off] : line_dat[last_idx][req_off];
      end else if (arr_hit) begin
        cpu_ack   = 1'b1;
        cpu_rdata = line_dat[arr_idx][req_off];
      end else if (buf_match && buf_wv[req_off]) begin
        cpu_ack   = 1'b1;
        src_buf   = 1'b1;
        cpu_rdata = buf_dat[req_off];
      end else if (fill_here) begin
        cpu_ack   = 1'b1;
        src_buf   = 1'b1;
        cpu_rdata = mem_rdata;
      end
    end else if (wr_done) begin
      cpu_ack = 1'b1;
    end
  end

  // memory port: fill owns it while busy, otherwise a write may use it
  assign mem_req   = fill_busy || (cpu_req && cpu_we);
  assign mem_we    = !fill_busy && cpu_req && cpu_we;
  assign mem_addr  = fill_busy ? {buf_tag, fill_ptr} : cpu_addr;
  assign mem_wdata = cpu_wdata;

  // next state
  always_comb begin
    line_tag_n  = line_tag;
    line_vld_n  = line_vld;
    line_dat_n  = line_dat;
    buf_tag_n   = buf_tag;
    buf_vld_n   = buf_vld;
    buf_wv_n    = buf_wv;
    buf_dat_n   = buf_dat;
    fill_busy_n = fill_busy;
    fill_ptr_n  = fill_ptr;
    fill_cnt_n  = fill_cnt;
    last_vld_n  = last_vld;
    last_buf_n  = last_buf;
    last_idx_n  = last_idx;
    last_addr_n = last_addr;

    if (fill_busy && mem_ack) begin
      buf_dat_n[fill_ptr] = mem_rdata;
      buf_wv_n[fill_ptr]  = 1'b1;
      fill_ptr_n          = wrap_next(fill_ptr);
      fill_cnt_n          = fill_cnt + 1'b1;
      if (fill_cnt == OFF_W'(LW-1)) fill_busy_n = 1'b0;
    end

    if (miss_start) begin
      if (buf_vld) begin
        line_tag_n[rnd[IDX_W-1:0]] = buf_tag;
        line_vld_n[rnd[IDX_W-1:0]] = 1'b1;
        line_dat_n[rnd[IDX_W-1:0]] = buf_dat;
      end
      buf_tag_n   = req_tag;
      buf_vld_n   = 1'b1;
      buf_wv_n    = '0;
      fill_ptr_n  = req_off;
      fill_cnt_n  = '0;
      fill_busy_n = 1'b1;
      last_vld_n  = 1'b0;
    end

    if (wr_done) begin
      if (arr_hit)   line_dat_n[arr_idx][req_off] = cpu_wdata;
      if (buf_match) buf_dat_n[req_off]           = cpu_wdata;
      last_vld_n = 1'b0;
    end

    if (rd && cpu_ack) begin
      last_vld_n  = 1'b1;
      last_buf_n  = src_buf;
      last_idx_n  = src_idx;
      last_addr_n = cpu_addr;
    end
  end

  // control registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      line_tag  <= '0;
      line_vld  <= '0;
      buf_tag   <= '0;
      buf_vld   <= 1'b0;
      buf_wv    <= '0;
      fill_busy <= 1'b0;
      fill_ptr  <= '0;
      fill_cnt  <= '0;
      last_vld  <= 1'b0;
      last_buf  <= 1'b0;
      last_idx  <= '0;
      last_addr <= '0;
    end else begin
      line_tag  <= line_tag_n;
      line_vld  <= line_vld_n;
      buf_tag   <= buf_tag_n;
      buf_vld   <= buf_vld_n;
      buf_wv    <= buf_wv_n;
      fill_busy <= fill_busy_n;
      fill_ptr  <= fill_ptr_n;
      fill_cnt  <= fill_cnt_n;
      last_vld  <= last_vld_n;
      last_buf  <= last_buf_n;
      last_idx  <= last_idx_n;
      last_addr <= last_addr_n;
    end
  end

  // data storage: no reset, guarded by the valid bits
  always_ff @(posedge clk) begin
    line_dat <= line_dat_n;
    buf_dat  <= buf_dat_n;
  end
endmodule

// File: rtl/lfb_cache_chk.sv
module lfb_cache_chk #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_req,
  input logic          cpu_we,
  input logic [AW-1:0] cpu_addr,
  input logic [DW-1:0] cpu_wdata,
  input logic          cpu_ack,
  input logic [DW-1:0] cpu_rdata,
  input logic          cpu_seq,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ack,
  input logic [DW-1:0] mem_rdata
);
  // R2
  crit_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_we && cpu_ack && mem_ack && !mem_we && mem_addr == cpu_addr)
      |-> cpu_rdata == mem_rdata);

  // R3
  fill_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && $past(mem_req && !mem_we && mem_ack))
      |-> (mem_addr[AW-1:2] == $past(mem_addr[AW-1:2]))
          && (mem_addr[1:0] == $past(mem_addr[1:0]) + 2'd1));

  // R7
  seq_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_seq |-> (cpu_ack && cpu_req && !cpu_we));

  // R8
  write_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we && cpu_ack)
      |-> (mem_req && mem_we && mem_ack && mem_addr == cpu_addr && mem_wdata == cpu_wdata));

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

bind lfb_cache lfb_cache_chk #(.AW(AW), .DW(DW)) i_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
  .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata), .cpu_seq(cpu_seq),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_ack(mem_ack), .mem_rdata(mem_rdata)
);

// File: tb/test_lfb_cache.sv
`timescale 1ns/1ps
module test_lfb_cache;
  localparam int AW  = 10;
  localparam int DW  = 16;
  localparam int LAT = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cpu_req, cpu_we;
  logic [AW-1:0] cpu_addr;
  logic [DW-1:0] cpu_wdata;
  logic          cpu_ack, cpu_seq;
  logic [DW-1:0] cpu_rdata;
  logic          mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  always #5 clk = ~clk;

  lfb_cache #(.AW(AW), .DW(DW)) i_lfb_cache (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata), .cpu_seq(cpu_seq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // memory model with fixed latency and a transaction log
  logic [DW-1:0] mem [0:(1<<AW)-1];
  logic [AW-1:0] log_addr [0:255];
  logic          log_we   [0:255];
  int            log_n  = 0;
  int            rd_cnt = 0;
  int            lat_cnt = 0;

  function automatic logic [DW-1:0] pat(input int a);
    return DW'((a * 32'h0135) ^ 32'h5A00);
  endfunction

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = pat(i);
  end

  always @(posedge clk) begin
    if (mem_ack) begin
      mem_ack <= 1'b0;
      lat_cnt <= 0;
    end else if (mem_req) begin
      if (lat_cnt + 1 >= LAT) begin
        mem_ack   <= 1'b1;
        mem_rdata <= mem[mem_addr];
        if (mem_we) mem[mem_addr] <= mem_wdata;
        else        rd_cnt <= rd_cnt + 1;
        if (log_n < 256) begin
          log_addr[log_n] <= mem_addr;
          log_we[log_n]   <= mem_we;
        end
        log_n   <= log_n + 1;
        lat_cnt <= 0;
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cpu_rd(input logic [AW-1:0] a, output logic [DW-1:0] d, output bit seq,
                        output bit via_mem, output bit fill_act, output int waits);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a; waits = 0;
    #1;
    while (!cpu_ack) begin
      @(negedge clk); #1; waits++;
    end
    d = cpu_rdata; seq = cpu_seq; via_mem = mem_ack; fill_act = mem_req && !mem_we;
    @(posedge clk); #1;
    cpu_req = 1'b0;
  endtask

  task automatic cpu_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    #1;
    while (!cpu_ack) begin
      @(negedge clk); #1;
    end
    @(posedge clk); #1;
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic wait_idle();
    int q = 0;
    while (q < 4) begin
      @(negedge clk);
      if (!mem_req) q++; else q = 0;
    end
  endtask

  logic [DW-1:0] d;
  bit s, vm, fa;
  int w, base, rc;

  task automatic t_reset();
    @(negedge clk);
    chk(!cpu_ack && !cpu_seq && !mem_req, "R1 idle outputs", {cpu_ack, cpu_seq, mem_req}, 0);
    cpu_rd(10'h000, d, s, vm, fa, w);
    chk(vm, "R1 first read fetched", vm, 1);
    wait_idle();
  endtask

  task automatic t_miss_critical();
    base = log_n;
    cpu_rd(10'h042, d, s, vm, fa, w);
    chk(d == pat('h042), "R2 critical data", d, pat('h042));
    chk(vm, "R2 ack in arrival cycle", vm, 1);
    chk(log_addr[base] == 10'h042, "R2 first fetch address", log_addr[base], 'h042);
    wait_idle();
    chk(log_addr[base+1] == 10'h043 && log_addr[base+2] == 10'h040 && log_addr[base+3] == 10'h041,
        "R3 wrap order", {log_addr[base+1], log_addr[base+2], log_addr[base+3]}, 'h043_040_041);
  endtask

  task automatic t_hit_during_fill();
    cpu_rd(10'h080, d, s, vm, fa, w);
    rc = rd_cnt;
    cpu_rd(10'h041, d, s, vm, fa, w);
    chk(d == pat('h041), "R6 committed line data", d, pat('h041));
    chk(fa && w == 0, "R3 hit while fill runs", {fa, w[0]}, 2);
    wait_idle();
    chk(rd_cnt == rc + 3, "R6 no fetch for committed line", rd_cnt - rc, 3);
    rc = rd_cnt;
    cpu_rd(10'h083, d, s, vm, fa, w);
    chk(d == pat('h083) && w == 0, "R4 buffer hit data", d, pat('h083));
    chk(rd_cnt == rc, "R4 no memory read", rd_cnt - rc, 0);
  endtask

  task automatic t_pending();
    rc = rd_cnt;
    cpu_rd(10'h0C1, d, s, vm, fa, w);
    cpu_rd(10'h0C0, d, s, vm, fa, w);
    chk(d == pat('h0C0), "R5 pending word data", d, pat('h0C0));
    chk(w > 0 && vm, "R5 stalled then forwarded", w, 1);
    wait_idle();
    chk(rd_cnt == rc + 4, "R5 no extra read", rd_cnt - rc, 4);
  endtask

  task automatic t_seq();
    cpu_rd(10'h0C0, d, s, vm, fa, w);
    cpu_rd(10'h0C1, d, s, vm, fa, w);
    chk(s && d == pat('h0C1), "R7 seq from buffer", d, pat('h0C1));
    cpu_rd(10'h0C2, d, s, vm, fa, w);
    cpu_rd(10'h0C3, d, s, vm, fa, w);
    chk(s && d == pat('h0C3), "R7 seq run end", d, pat('h0C3));
    cpu_rd(10'h0C4, d, s, vm, fa, w);
    chk(!s && d == pat('h0C4), "R7 line cross not seq", s, 0);
    cpu_rd(10'h0C2, d, s, vm, fa, w);
    cpu_rd(10'h0C3, d, s, vm, fa, w);
    chk(s && d == pat('h0C3), "R7 seq from array", d, pat('h0C3));
    wait_idle();
  endtask

  task automatic t_write();
    cpu_rd(10'h200, d, s, vm, fa, w);
    wait_idle();
    base = log_n;
    cpu_wr(10'h201, 16'hBEEF);
    chk(log_we[base] && log_addr[base] == 10'h201, "R8 write issued", log_addr[base], 'h201);
    rc = rd_cnt;
    cpu_rd(10'h201, d, s, vm, fa, w);
    chk(d == 16'hBEEF && rd_cnt == rc, "R8 buffer updated", d, 'hBEEF);
    cpu_rd(10'h240, d, s, vm, fa, w);
    wait_idle();
    rc = rd_cnt;
    cpu_rd(10'h201, d, s, vm, fa, w);
    chk(d == 16'hBEEF && rd_cnt == rc, "R8 array copy updated", d, 'hBEEF);
    cpu_wr(10'h300, 16'h1234);
    cpu_rd(10'h300, d, s, vm, fa, w);
    chk(d == 16'h1234, "R8 memory written", d, 'h1234);
    wait_idle();
  endtask

  task automatic t_serial();
    base = log_n;
    cpu_rd(10'h140, d, s, vm, fa, w);
    cpu_rd(10'h180, d, s, vm, fa, w);
    chk(d == pat('h180), "R9 second miss data", d, pat('h180));
    chk(log_addr[base+3] == 10'h143 && log_addr[base+4] == 10'h180, "R9 miss after fill",
        log_addr[base+4], 'h180);
    cpu_wr(10'h1C0, 16'h0A0A);
    chk(log_we[base+8] && log_addr[base+8] == 10'h1C0 && log_addr[base+7] == 10'h183,
        "R9 write after fill", log_addr[base+8], 'h1C0);
    wait_idle();
  endtask

  initial begin
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    mem_ack = 1'b0; mem_rdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    t_reset();
    t_miss_critical();
    t_hit_during_fill();
    t_pending();
    t_seq();
    t_write();
    t_serial();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule